// File: doc/BRIEF.md
# Iterative Rectangular-to-Polar Converter

This block turns a signed 16-bit in-phase/quadrature sample pair into an unsigned magnitude and a phase angle. It uses a vectoring CORDIC that applies one micro-rotation per clock. The sample is first folded into the right half-plane by a quarter-turn rotation. The quarter-turn offset is preloaded into an 18-bit angle accumulator. Sixteen shift-and-add rotations then drive the vector onto the positive real axis. The magnitude carries the uncompensated CORDIC gain of about 1.64676.

A full-precision result is ready 17 cycles after a sample is taken. If the next sample arrives sooner, the block does not stall. It captures the partially rotated vector at once as the output and starts on the new sample. Faster sample rates therefore cost resolution, not throughput. The held results feed two downstream consumers. An output formatter reads the 16 most significant phase bits, and a frequency discriminator reads all 18 bits. A select input declares whether the 16-bit phase is read as a signed fraction of a cycle (-0.5 to just under +0.5) or an unsigned one (0 to just under 1.0).

Top module: `cordic_polar`

## Requirements
- R1: A sample is accepted on every clock with `smp_valid` high. Accepting a sample while no computation is running produces no output pulse on the next cycle.
- R2: With no further sample, the full-precision result appears 17 cycles after the acceptance edge. `res_valid` is high for exactly that one cycle.
- R3: Full-precision `phase_fmt` is within 12 codes (circularly) of the ideal angle. The encoding is 0x0000 = 0°, 0x4000 = 90°, 0x8000 = 180° and 0xC000 = 270°, with bit 15 weighing 180° and each lower bit half of the one above.
- R4: `mag` is unsigned. At full precision it is within 6 codes of 1.64676·sqrt(I²+Q²)/4. Bit 15 of `mag` is always 0.
- R5: `phase_disc` is 18 bits with an LSB of 360°/2^18, and its top 16 bits always equal `phase_fmt`.
- R6: When a new sample is accepted g cycles after the previous one (1 ≤ g < 17), the previous result is captured after g−1 rotations. It appears with `res_valid` on the cycle after the new acceptance edge, and the new sample restarts the computation.
- R7: With back-to-back samples (g = 1), the captured result is the folded vector. For I ≥ 0: phase 0x0000 and mag = floor(I/4). For I < 0 and Q ≥ 0: phase 0x4000 and mag = floor(Q/4). For I < 0 and Q < 0: phase 0xC000 and mag = floor(−Q/4).
- R8: A result captured after k ≥ 1 rotations has phase within atan(2^(1−k))/(2π)·65536 + 12 codes of the ideal angle.
- R9: The `phase_signed` select leaves the phase bit pattern unchanged. The same input gives the same codes under both settings.
- R10: Synchronous reset clears `res_valid`, `mag` and both phase outputs. Between result pulses, all outputs hold their last captured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe; I/Q are taken on this edge |
| smp_i | input | 16 | In-phase sample, two's complement |
| smp_q | input | 16 | Quadrature sample, two's complement |
| phase_signed | input | 1 | 1: phase read as signed cycles, 0: unsigned |
| res_valid | output | 1 | One-cycle pulse when the held results update |
| mag | output | 16 | Held magnitude, unsigned, gain uncompensated |
| phase_fmt | output | 16 | Held phase, 16 MSBs for the formatter |
| phase_disc | output | 18 | Held phase, full 18 bits for the discriminator |

## Verification
The block's hidden state is a rotation counter, a busy flag and the rotating vector. A wrong iteration count or busy flag shows up at once as a `res_valid` pulse on the wrong cycle. The scoreboard stamps each expected result with its exact arrival cycle, so that error is caught on the first sample it affects. A wrong arctangent constant, shift amount or fold direction corrupts the angle accumulator and is caught on the next captured phase. Back-to-back samples expose the fold step exactly, before any rotation can mask it. Phases captured after a known number of rotations expose the rotation sequence step by step.

// File: rtl/polar_pkg.sv
package polar_pkg;

    localparam int DW    = 16;          // sample and output width
    localparam int GUARD = 4;           // extra integer bits in the rotating vector
    localparam int XW    = DW + GUARD;  // rotating vector width
    localparam int ZW    = 18;          // angle accumulator width
    localparam int ITERS = 16;          // micro-rotations for full precision
    localparam int IDXW  = $clog2(ITERS);
    localparam int CNTW  = $clog2(ITERS + 1);

    typedef logic signed [XW-1:0] xy_t;
    typedef logic        [ZW-1:0] ang_t;

    typedef struct packed {
        xy_t  x;
        xy_t  y;
        ang_t z;
    } vec_t;

    localparam ang_t QUARTER = ang_t'(1) << (ZW - 2);

    // atan(2^-i) in units of one cycle / 2^18, rounded
    function automatic ang_t atan_step(input logic [IDXW-1:0] i);
        case (i)
            4'd0:    atan_step = 18'd32768;
            4'd1:    atan_step = 18'd19344;
            4'd2:    atan_step = 18'd10221;
            4'd3:    atan_step = 18'd5188;
            4'd4:    atan_step = 18'd2604;
            4'd5:    atan_step = 18'd1303;
            4'd6:    atan_step = 18'd652;
            4'd7:    atan_step = 18'd326;
            4'd8:    atan_step = 18'd163;
            4'd9:    atan_step = 18'd81;
            4'd10:   atan_step = 18'd41;
            4'd11:   atan_step = 18'd20;
            4'd12:   atan_step = 18'd10;
            4'd13:   atan_step = 18'd5;
            4'd14:   atan_step = 18'd3;
            default: atan_step = 18'd1;
        endcase
    endfunction

    // signed and unsigned readings share one bit pattern on the full circle
    function automatic logic [DW-1:0] fmt_phase(input ang_t z, input logic signed_mode);
        logic [DW-1:0] top;
        top = z[ZW-1:ZW-DW];
        fmt_phase = signed_mode ? DW'($signed(top)) : top;
    endfunction

endpackage

// File: rtl/polar_prerot.sv
module polar_prerot
    import polar_pkg::*;
(
    input  logic signed [DW-1:0] i_in,
    input  logic signed [DW-1:0] q_in,
    output vec_t                 v_out
);
    xy_t xi, xq;

    always_comb begin
        xi = xy_t'(i_in);
        xq = xy_t'(q_in);
        if (!i_in[DW-1]) begin
            v_out = '{x: xi, y: xq, z: '0};
        end else if (!q_in[DW-1]) begin
            // second quadrant: turn by -90 degrees, remember +90
            v_out = '{x: xq, y: -xi, z: QUARTER};
        end else begin
            // third quadrant: turn by +90 degrees, remember 270
            v_out = '{x: -xq, y: xi, z: 3 * QUARTER};
        end
    end
endmodule

// File: rtl/polar_micro_rot.sv
module polar_micro_rot
    import polar_pkg::*;
(
    input  vec_t            v_in,
    input  logic [IDXW-1:0] idx,
    output vec_t            v_out
);
    xy_t  xs, ys, x_sh, y_sh;
    ang_t da;

    always_comb begin
        xs   = v_in.x;
        ys   = v_in.y;
        x_sh = xs >>> idx;
        y_sh = ys >>> idx;
        da   = atan_step(idx);
        if (!ys[XW-1]) begin
            v_out = '{x: xs + y_sh, y: ys - x_sh, z: v_in.z + da};
        end else begin
            v_out = '{x: xs - y_sh, y: ys + x_sh, z: v_in.z - da};
        end
    end
endmodule

// File: rtl/polar_engine.sv
module polar_engine
    import polar_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic signed [DW-1:0] i_in,
    input  logic signed [DW-1:0] q_in,
    output logic                 busy,
    output logic                 done,
    output logic [DW-1:0]        mag_now,
    output ang_t                 ang_now
);
    localparam logic [CNTW-1:0] LAST = CNTW'(ITERS);

    vec_t            st, st_pre, st_rot;
    logic [CNTW-1:0] cnt;

    polar_prerot u_prerot (.i_in(i_in), .q_in(q_in), .v_out(st_pre));
    polar_micro_rot u_rot (.v_in(st), .idx(cnt[IDXW-1:0]), .v_out(st_rot));

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= '0;
            cnt  <= '0;
            busy <= 1'b0;
        end else if (load) begin
            st   <= st_pre;
            cnt  <= '0;
            busy <= 1'b1;
        end else if (busy) begin
            if (cnt == LAST) begin
                busy <= 1'b0;
            end else begin
                st  <= st_rot;
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign done    = busy && (cnt == LAST);
    assign mag_now = st.x[DW+1:2];
    assign ang_now = st.z;

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R2
    idle_count_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> cnt == '0 || cnt == LAST);
endmodule

// File: rtl/cordic_polar.sv
module cordic_polar
    import polar_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_valid,
    input  logic [15:0]   smp_i,
    input  logic [15:0]   smp_q,
    input  logic          phase_signed,
    output logic          res_valid,
    output logic [15:0]   mag,
    output logic [15:0]   phase_fmt,
    output logic [17:0]   phase_disc
);
    logic          busy, done, capture;
    logic [DW-1:0] mag_now;
    ang_t          ang_now;
    logic [DW-1:0] hold_mag;
    ang_t          hold_ang;

    polar_engine u_engine (
        .clk     (clk),
        .rst     (rst),
        .load    (smp_valid),
        .i_in    ($signed(smp_i)),
        .q_in    ($signed(smp_q)),
        .busy    (busy),
        .done    (done),
        .mag_now (mag_now),
        .ang_now (ang_now)
    );

    // capture on completion or when a new sample cuts the work short
    assign capture = done || (smp_valid && busy);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_mag  <= '0;
            hold_ang  <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= capture;
            if (capture) begin
                hold_mag <= mag_now;
                hold_ang <= ang_now;
            end
        end
    end

    assign mag        = hold_mag;
    assign phase_disc = hold_ang;
    assign phase_fmt  = fmt_phase(hold_ang, phase_signed);

    // R4
    mag_msb_chk: assert property (@(posedge clk) disable iff (rst)
        mag[15] == 1'b0);

    // R6
    early_latch_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid && busy |=> res_valid);

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done && !smp_valid |=> res_valid && !busy);

    // R1
    idle_accept_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid && !busy |=> !res_valid);

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> $stable(mag) && $stable(phase_disc));
endmodule

// File: tb/cordic_polar_bench.sv
module cordic_polar_bench;

    typedef struct {
        int    exp_cyc;
        int    mag_exp;
        int    mag_tol;   // negative: magnitude not checked
        int    ph_exp;
        int    ph_tol;
        string tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_i = '0;
    logic [15:0] smp_q = '0;
    logic        phase_signed = 1'b0;
    logic        res_valid;
    logic [15:0] mag;
    logic [15:0] phase_fmt;
    logic [17:0] phase_disc;

    item_t q_exp[$];
    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc = 0;
    logic [15:0] last_mag = '0;
    logic [17:0] last_ph = '0;

    localparam real PI   = 3.14159265358979;
    localparam real GAIN = 1.64676025812107;

    cordic_polar u_cordic_polar (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
        .phase_signed(phase_signed), .res_valid(res_valid), .mag(mag),
        .phase_fmt(phase_fmt), .phase_disc(phase_disc)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int circ_diff(input int a, input int b);
        int d;
        d = (a - b) & 16'hFFFF;
        if (d > 32768) d = d - 65536;
        return (d < 0) ? -d : d;
    endfunction

    function automatic int ideal_phase(input int i, input int q);
        real t;
        t = $atan2(real'(q), real'(i)) / (2.0 * PI);
        if (t < 0.0) t = t + 1.0;
        return int'(t * 65536.0) & 16'hFFFF;
    endfunction

    // gap: cycles until the next acceptance (>=17 means the result completes)
    task automatic send(input int i, input int q, input int gap, input string tag);
        item_t it;
        int k;
        k = (gap >= 17) ? 16 : gap - 1;
        it.tag     = tag;
        it.exp_cyc = cyc + 1 + ((gap >= 17) ? 17 : gap);
        if (k == 0) begin
            // R7: folded vector only
            if (i >= 0) begin
                it.ph_exp = 0;      it.mag_exp = i >>> 2;
            end else if (q >= 0) begin
                it.ph_exp = 16'h4000; it.mag_exp = q >>> 2;
            end else begin
                it.ph_exp = 16'hC000; it.mag_exp = (-q) >>> 2;
            end
            it.ph_tol  = 0;
            it.mag_tol = 0;
        end else if (k < 16) begin
            // R8: bounded residual after k rotations
            it.ph_exp  = ideal_phase(i, q);
            it.ph_tol  = int'($atan(2.0 ** (1 - k)) / (2.0 * PI) * 65536.0) + 12;
            it.mag_tol = -1;
            it.mag_exp = 0;
        end else begin
            // R3 / R4: full precision
            it.ph_exp  = ideal_phase(i, q);
            it.ph_tol  = 12;
            it.mag_exp = int'(GAIN * $sqrt(real'(i) * i + real'(q) * q) / 4.0);
            it.mag_tol = 6;
        end
        q_exp.push_back(it);
        smp_i     = 16'(i);
        smp_q     = 16'(q);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (gap - 1) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (res_valid) begin
                if (q_exp.size() == 0) begin
                    check(1'b0, "R1 unexpected res_valid", 1, 0);
                end else begin
                    item_t it;
                    it = q_exp.pop_front();
                    check(cyc == it.exp_cyc, {"R2/R6 timing ", it.tag}, cyc, it.exp_cyc);
                    check(circ_diff(int'(phase_fmt), it.ph_exp) <= it.ph_tol,
                          {"R3/R7/R8 phase ", it.tag}, int'(phase_fmt), it.ph_exp);
                    if (it.mag_tol >= 0) begin
                        int d;
                        d = int'(mag) - it.mag_exp;
                        if (d < 0) d = -d;
                        check(d <= it.mag_tol, {"R4/R7 mag ", it.tag}, int'(mag), it.mag_exp);
                    end
                    check(mag[15] == 1'b0, "R4 mag msb", int'(mag[15]), 0);
                    check(phase_disc[17:2] == phase_fmt, "R5 phase_disc top bits",
                          int'(phase_disc[17:2]), int'(phase_fmt));
                end
                last_mag = mag;
                last_ph  = phase_disc;
            end else if (mag != last_mag || phase_disc != last_ph) begin
                check(1'b0, "R10 outputs held", int'(phase_disc), int'(last_ph));
            end
        end
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        check(1'b0, "watchdog expired", cyc, 5000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset values
        check(res_valid == 1'b0, "R10 reset res_valid", int'(res_valid), 0);
        check(mag == '0, "R10 reset mag", int'(mag), 0);
        check(phase_disc == '0, "R10 reset phase_disc", int'(phase_disc), 0);
        check(phase_fmt == '0, "R10 reset phase_fmt", int'(phase_fmt), 0);
        rst = 1'b0;
        @(negedge clk);

        // full-precision vectors around the circle (R2, R3, R4)
        send( 20000,      0, 20, "east");
        send(     0,  20000, 20, "north");
        send(-20000,      0, 20, "west");
        send(     0, -20000, 20, "south");
        send( 12345, -23456, 20, "q4");
        send(-32768, -32768, 20, "max neg");
        send( 32767,  32767, 20, "max pos");
        send(-18000,  25000, 20, "q2");

        // early latching (R6, R7, R8), signed phase reading
        phase_signed = 1'b1;
        send(-20000,  -5000,  1, "b2b q3 signed");
        send( 10000,  15000,  1, "b2b q1");
        send(-15000,  25000,  5, "k4");
        send( 25000, -10000, 12, "k11");
        send(-20000,  20000, 16, "k15");
        send( 16000, -30000, 17, "gap17 full");
        send(-25000, -12000, 20, "after gap17");

        // R9: same inputs, unsigned reading, identical codes expected
        phase_signed = 1'b0;
        send(-20000,  -5000,  1, "b2b q3 unsigned");
        send(    -7,      9,  1, "b2b small q2");
        send(-25000, -12000, 20, "unsigned full");

        repeat (5) @(negedge clk);
        check(q_exp.size() == 0, "R2 all results delivered", q_exp.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule